// File: doc/BRIEF.md
# UART Receive Queue with Fill-Level Interrupt

This block holds received characters between a serial receiver and the bus-side data register of a UART-style peripheral. The receiver offers 12-bit entries, made of 8 data bits in bits 7:0 and four error bits above them. Bit 10 is the break bit. The bus side sees the oldest entry at all times and consumes it with a one-cycle pop strobe. The block reports whether it is empty or full, and whether it can accept another entry. It also keeps a receive-interrupt status bit that follows a programmable fill level.

A line-control value selects between two depths. In queue mode the block holds up to 16 entries. With queue mode off it behaves as a single holding register. The fill level is decoded from a level-select value. It is latched only when the configuration write strobe is pulsed, so the line-control and level-select inputs can change freely between writes. When the receiver reports a line break, the block stores a dedicated break entry in the data stream.

Top module: `uart_rx_queue`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the block reports empty=1, full=0, rx_irq=0, overrun=0 and can_accept=1. The latched fill level is 1.
- R2: Entries come out in the order they were accepted, with up to 16 stored. head_entry always shows the oldest stored entry, including after the storage wraps around.
- R3: can_accept is high when bit 4 of cfg_lcr is set and fewer than 16 entries are stored, or when bit 4 is clear and nothing is stored. It is low otherwise.
- R4: A push offered while can_accept is low stores nothing. overrun is then high for exactly the following cycle.
- R5: empty is high exactly when no entry is stored. full is set by an accepted push that brings the count to 16, or by any accepted push while queue mode is off. Any pop strobe clears full.
- R6: On a cycle with cfg_wr high, the fill level becomes 4 × cfg_ifl[5:3] when cfg_lcr bit 4 is set. It becomes 1 when that product is 0 or when bit 4 is clear. Products above 16 are never reached, so they never raise rx_irq.
- R7: The latched fill level changes only on cycles with cfg_wr high.
- R8: rx_irq is set in the cycle after an accepted push that makes the stored count exactly equal to the fill level.
- R9: rx_irq is cleared in the cycle after a pop that leaves the stored count exactly one below the fill level. If the same cycle also meets the condition of R8, the set wins.
- R10: A break_valid push stores the entry 0x400 (only bit 10 set, zero data). It takes precedence over push_valid in the same cycle.
- R11: A pop while empty changes no stored state. empty stays high, rx_irq is unchanged, and the next accepted entry is the one that appears at head_entry.
- R12: A push and a pop may occur in the same cycle, and both take effect. Acceptance of the push is judged on the count before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Receiver offers push_entry this cycle |
| push_entry | input | 12 | Received entry: data in 7:0, error bits in 11:8 |
| break_valid | input | 1 | Receiver detected a line break; store the break entry |
| pop | input | 1 | Bus read of the data register consumes head_entry |
| cfg_wr | input | 1 | Line-control or level-select register was written |
| cfg_lcr | input | 8 | Line-control value; bit 4 enables 16-deep queue mode |
| cfg_ifl | input | 6 | Level-select value; bits 5:3 pick the fill level |
| head_entry | output | 12 | Oldest stored entry |
| can_accept | output | 1 | A push this cycle would be stored |
| empty | output | 1 | No entry stored |
| full | output | 1 | Full flag |
| rx_irq | output | 1 | Receive interrupt status |
| overrun | output | 1 | One-cycle pulse after a dropped push |

## Verification
The bench targets four kinds of corner case.

- **Fill-level boundaries.** It pushes one short of each level, then exactly to it, then pops one back. A design that compared with "at least" instead of "equal", or that left the interrupt set after the drain, would show a wrong rx_irq in those cycles.
- **Full storage.** It fills to 16, pushes once more and drains across the wrap of the pointer. A wrong slot computation would reorder head_entry, and a missing guard would corrupt the oldest entry instead of pulsing overrun.
- **Configuration handling.** It changes the level-select value without the write strobe, and sets level codes beyond the depth. A design that decoded the level live would move the interrupt point, and one that saturated large codes would fire at 16.
- **Same-cycle traffic.** It pops an empty block and pushes while popping a full block. An unguarded pop would drop the next entry, and acceptance judged after the pop would store data that should be lost.

// File: rtl/rxq_pkg.sv
// Package: shared constants and types for the UART receive queue.
// Assumes a 12-bit entry with 8 data bits and the break flag in bit 10.
package rxq_pkg;
    localparam int ENTRY_W  = 12;
    localparam int DATA_W   = 8;
    localparam int BRK_BIT  = 10;
    localparam int LVL_W    = 3;   // width of the level-select code
    typedef logic [ENTRY_W-1:0] rx_entry_t;
    localparam rx_entry_t BREAK_ENTRY = rx_entry_t'(1) << BRK_BIT;
endpackage

// File: rtl/rxq_trig.sv
// Module: holds the fill level that drives the receive interrupt.
// Assumes the level is sampled only on configuration writes; a level of
// zero or single-register mode both map to a level of one.
module rxq_trig #(
    parameter int TRG_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic                     queue_mode,
    input  logic [rxq_pkg::LVL_W-1:0] lvl_code,
    output logic [TRG_W-1:0]         trig
);
    localparam logic [TRG_W-1:0] ONE = TRG_W'(1);

    logic [TRG_W-1:0] decoded;

    // Purpose: turn the level code into a fill count, four entries per step.
    always_comb begin
        decoded = TRG_W'({lvl_code, 2'b00});
        if (!queue_mode || decoded == '0) decoded = ONE;
    end

    // Purpose: latch the decoded level on each configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n)      trig <= ONE;
        else if (cfg_wr) trig <= decoded;
    end

    a_r7_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(trig));
    a_r6_trig_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (trig != '0));
endmodule

// File: rtl/rxq_store.sv
// Module: entry storage, written at a given slot, read at the read pointer.
// Assumes the caller never writes an occupied slot; depth is a power of two.
module rxq_store #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PTR_W-1:0]    wr_slot,
    input  rxq_pkg::rx_entry_t  wr_data,
    input  logic [PTR_W-1:0]    rd_ptr,
    output rxq_pkg::rx_entry_t  rd_data
);
    rxq_pkg::rx_entry_t mem [DEPTH];

    // Purpose: clear storage on reset, then write accepted entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_slot] <= wr_data;
        end
    end

    // Purpose: present the entry under the read pointer.
    always_comb rd_data = mem[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
// Module: occupancy count, read pointer, flags and interrupt status.
// Assumes pop is handled before push within a cycle, while push acceptance
// uses the count from before the cycle.
module rxq_ctrl #(
    parameter int DEPTH = 16,
    parameter int TRG_W = 5,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             queue_mode,
    input  logic [TRG_W-1:0] trig,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_slot,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             can_accept,
    output logic             empty,
    output logic             full,
    output logic             irq,
    output logic             overrun
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count, cnt_pop, cnt_nxt;
    logic [TRG_W-1:0] cnt_pop_x, cnt_nxt_x, trig_m1;
    logic             pop_ok;

    // Purpose: decide acceptance, the effective pop and the next count.
    always_comb begin
        can_accept = queue_mode ? (count < FULL_CNT) : (count == '0);
        wr_en      = push_req && can_accept;
        pop_ok     = pop_req && (count != '0);
        cnt_pop    = count - CNT_W'(pop_ok);
        cnt_nxt    = cnt_pop + CNT_W'(wr_en);
        wr_slot    = rd_ptr + count[PTR_W-1:0];
        cnt_pop_x  = TRG_W'(cnt_pop);
        cnt_nxt_x  = TRG_W'(cnt_nxt);
        trig_m1    = trig - TRG_W'(1);
        empty      = (count == '0);
    end

    // Purpose: advance count and read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            rd_ptr <= '0;
        end else begin
            count  <= cnt_nxt;
            rd_ptr <= rd_ptr + PTR_W'(pop_ok);
        end
    end

    // Purpose: full flag, set by a filling push, cleared by any pop strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          full <= 1'b0;
        else if (wr_en && (cnt_nxt == FULL_CNT || !queue_mode)) full <= 1'b1;
        else if (pop_req)                                    full <= 1'b0;
    end

    // Purpose: interrupt status, set at the level, cleared one below it.
    always_ff @(posedge clk) begin
        if (!rst_n)                             irq <= 1'b0;
        else if (wr_en && cnt_nxt_x == trig)    irq <= 1'b1;
        else if (pop_ok && cnt_pop_x == trig_m1) irq <= 1'b0;
    end

    // Purpose: one-cycle pulse for a push that found no room.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= push_req && !can_accept;
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r4_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !can_accept && !pop_req) |=> $stable(count));
    a_r11_empty_pop_still: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_req) |=> ($stable(rd_ptr) && empty));
    a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(push_req));
    a_r5_single_mode_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !queue_mode) |=> full);
endmodule

// File: rtl/uart_rx_queue.sv
// Module: top of the UART receive queue; joins storage, control and level.
// Assumes one push source (data or break) and one pop per cycle at most.
module uart_rx_queue #(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_valid,
    input  logic [11:0] push_entry,
    input  logic        break_valid,
    input  logic        pop,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_lcr,
    input  logic [5:0]  cfg_ifl,
    output logic [11:0] head_entry,
    output logic        can_accept,
    output logic        empty,
    output logic        full,
    output logic        rx_irq,
    output logic        overrun
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam int TRG_W = (CNT_W > 5) ? CNT_W : 5;
    localparam int MODE_BIT = 4;

    logic               queue_mode, push_req, wr_en;
    logic [PTR_W-1:0]   wr_slot, rd_ptr;
    logic [TRG_W-1:0]   trig;
    rxq_pkg::rx_entry_t in_entry;

    // Purpose: merge the data and break sources into one push.
    always_comb begin
        queue_mode = cfg_lcr[MODE_BIT];
        push_req   = push_valid || break_valid;
        in_entry   = break_valid ? rxq_pkg::BREAK_ENTRY : push_entry;
    end

    rxq_trig #(.TRG_W(TRG_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .queue_mode(queue_mode),
        .lvl_code(cfg_ifl[5:3]), .trig(trig)
    );

    rxq_ctrl #(.DEPTH(DEPTH), .TRG_W(TRG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop),
        .queue_mode(queue_mode), .trig(trig), .wr_en(wr_en),
        .wr_slot(wr_slot), .rd_ptr(rd_ptr), .can_accept(can_accept),
        .empty(empty), .full(full), .irq(rx_irq), .overrun(overrun)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_data(in_entry), .rd_ptr(rd_ptr), .rd_data(head_entry)
    );

    a_r10_break_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (break_valid && can_accept && empty && !pop) |=> (head_entry == rxq_pkg::BREAK_ENTRY));
endmodule

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0, break_valid = 1'b0, pop = 1'b0, cfg_wr = 1'b0;
    logic [11:0] push_entry = '0;
    logic [7:0]  cfg_lcr = '0;
    logic [5:0]  cfg_ifl = '0;
    logic [11:0] head_entry;
    logic        can_accept, empty, full, rx_irq, overrun;

    int checks = 0, fails = 0, cycles = 0;

    // Reference model state
    logic [11:0] mq[$];
    int          mtrig = 1;
    bit          mfull = 0, mirq = 0, movr = 0;

    always #4 clk = ~clk;

    uart_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_entry(push_entry),
        .break_valid(break_valid), .pop(pop), .cfg_wr(cfg_wr), .cfg_lcr(cfg_lcr),
        .cfg_ifl(cfg_ifl), .head_entry(head_entry), .can_accept(can_accept),
        .empty(empty), .full(full), .rx_irq(rx_irq), .overrun(overrun)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, one step per clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); mtrig = 1; mfull = 0; mirq = 0; movr = 0;
        end else begin
            bit fifo, acc, pushing;
            int lvl;
            fifo    = cfg_lcr[4];
            acc     = fifo ? (mq.size() < 16) : (mq.size() == 0);
            pushing = push_valid || break_valid;
            movr    = pushing && !acc;
            if (pop) mfull = 0;
            if (pop && mq.size() > 0) begin
                void'(mq.pop_front());
                if (mq.size() == mtrig - 1) mirq = 0;
            end
            if (pushing && acc) begin
                mq.push_back(break_valid ? 12'h400 : push_entry);
                if (mq.size() == 16 || !fifo) mfull = 1;
                if (mq.size() == mtrig) mirq = 1;
            end
            if (cfg_wr) begin
                lvl   = 4 * int'(cfg_ifl[5:3]);
                mtrig = (!fifo || lvl == 0) ? 1 : lvl;
            end
        end
    end

    task automatic compare_all();
        bit fifo;
        fifo = cfg_lcr[4];
        check(32'(empty), 32'(mq.size() == 0), "R5 empty");
        check(32'(full), 32'(mfull), "R5 full");
        check(32'(rx_irq), 32'(mirq), "R8 R9 rx_irq");
        check(32'(overrun), 32'(movr), "R4 overrun");
        check(32'(can_accept), 32'(fifo ? (mq.size() < 16) : (mq.size() == 0)), "R3 can_accept");
        if (mq.size() > 0) check(32'(head_entry), 32'(mq[0]), "R2 head_entry");
    endtask

    task automatic cyc(input bit p, input logic [11:0] e, input bit b, input bit pp);
        push_valid = p; push_entry = e; break_valid = b; pop = pp;
        @(posedge clk); #2;
        push_valid = 0; break_valid = 0; pop = 0; cfg_wr = 0;
        compare_all();
    endtask

    task automatic push(input logic [11:0] e);
        cyc(1, e, 0, 0);
    endtask

    task automatic pop1();
        cyc(0, '0, 0, 1);
    endtask

    task automatic drain();
        for (int i = 0; i < 20 && !empty; i++) pop1();
    endtask

    task automatic configure(input logic [7:0] lcr, input logic [5:0] ifl);
        cfg_lcr = lcr; cfg_ifl = ifl; cfg_wr = 1;
        cyc(0, '0, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(posedge clk); #2;
        // R1 reset state
        check(32'(empty), 1, "R1 empty");
        check(32'(full), 0, "R1 full");
        check(32'(rx_irq), 0, "R1 rx_irq");
        check(32'(can_accept), 1, "R1 can_accept");
        check(32'(overrun), 0, "R1 overrun");

        // Single-register mode, level 1
        push(12'h0A5);
        check(32'(rx_irq), 1, "R8 single entry");
        check(32'(full), 1, "R5 single mode full");
        check(32'(can_accept), 0, "R3 single mode");
        push(12'h0FF);
        check(32'(overrun), 1, "R4 overrun pulse");
        check(32'(head_entry), 12'h0A5, "R4 head kept");
        cyc(0, '0, 0, 0);
        check(32'(overrun), 0, "R4 one cycle");
        pop1();
        check(32'(rx_irq), 0, "R9 cleared at zero");
        pop1();
        check(32'(empty), 1, "R11 empty pop");
        check(32'(rx_irq), 0, "R11 irq kept");
        push(12'h011);
        check(32'(head_entry), 12'h011, "R11 next entry");
        pop1();

        // Queue mode, level 8
        configure(8'h10, 6'h10);
        for (int i = 0; i < 7; i++) push(12'(i + 8'h30));
        check(32'(rx_irq), 0, "R6 below level 8");
        push(12'h137);
        check(32'(rx_irq), 1, "R8 level 8 reached");
        pop1();
        check(32'(rx_irq), 0, "R9 one below level");
        for (int i = 0; i < 9; i++) push(12'(i + 12'h240));
        check(32'(full), 1, "R5 full at 16");
        push(12'h0EE);
        check(32'(overrun), 1, "R4 full drop");
        cyc(1, 12'h0DD, 0, 1);
        check(32'(overrun), 1, "R12 judged before pop");
        drain();

        // Level register changed without a write strobe
        cfg_ifl = 6'h20;
        for (int i = 0; i < 8; i++) push(12'(i + 12'h350));
        check(32'(rx_irq), 1, "R7 level still 8");
        drain();

        // Level 16
        configure(8'h10, 6'h20);
        for (int i = 0; i < 15; i++) push(12'(i + 12'h060));
        check(32'(rx_irq), 0, "R6 level 16 not yet");
        push(12'h07F);
        check(32'(rx_irq), 1, "R6 level 16");
        drain();

        // Code 7: level beyond depth
        configure(8'h10, 6'h38);
        for (int i = 0; i < 16; i++) push(12'(i + 12'h080));
        check(32'(rx_irq), 0, "R6 level beyond depth");
        drain();

        // Code 0 in queue mode: level 1
        configure(8'h10, 6'h00);
        push(12'h055);
        check(32'(rx_irq), 1, "R6 level zero maps to one");

        // Break has priority
        cyc(1, 12'h0FF, 1, 0);
        pop1();
        check(32'(head_entry), 12'h400, "R10 break entry");

        // Simultaneous push and pop
        push(12'h0C1);
        cyc(1, 12'h0C2, 0, 1);
        check(32'(head_entry), 12'h0C1, "R12 pop with push");
        pop1();
        check(32'(head_entry), 12'h0C2, "R12 pushed entry kept");
        drain();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule